// File: doc/BRIEF.md
# Nonvolatile Register Backup Sequencer

This block runs the backup and restore of a bank of nonvolatile shadow flip-flops. A system becomes nonvolatile by pairing every state register with a nonvolatile storage element. A single level input states what the system wants. A low level means power is going away, so the register state must be written into the shadow cells. A high level means power is back, so the state must be read out of the cells again. The controller compares this level with the state it last reached and runs the matching sequence.

Each sequence has three timed phases: precharge, plate-line pulse and settle. Three cascaded cycle counters time these phases, one counter per phase. Each counter starts when the one before it overflows. The store lengths and the recall lengths are separate parameters. A registered clock-gate output freezes all volatile and nonvolatile registers while a sequence runs. The gate stays closed after a store, and also after reset until the first recall has completed. The busy output covers the whole sequence, and a one-cycle done pulse marks its end.

Top module: `nvff_backup_ctrl`

## Requirements
- R1: During reset and after it, `ff_clk_gate` is 1 and `cell_rw`, `cell_pch`, `cell_pl`, `busy` and `done` are 0. While `wake_req` stays 0 after reset, no sequence starts.
- R2: `wake_req` = 1 while asleep starts a recall, which drives `cell_rw` = 0 (read) in every busy cycle. `wake_req` = 0 while awake starts a store, which drives `cell_rw` = 1 (write) in every busy cycle. `cell_rw` is 0 whenever `busy` is 0.
- R3: A sequence drives `cell_pch` alone for T1 cycles, then `cell_pl` alone for T2 cycles, then neither for T3 cycles. The store lengths (default 3, 6, 4) and the recall lengths (default 2, 3, 2) are separate parameters.
- R4: `cell_pch` and `cell_pl` are never 1 in the same cycle.
- R5: `ff_clk_gate` is 1 in every busy cycle. After a recall it drops to 0 in the done cycle and stays 0. After a store it stays 1.
- R6: `busy` is 1 for exactly T1+T2+T3 consecutive cycles. `done` is 1 for exactly one cycle, the cycle right after the last busy cycle, and `busy` is 0 in that cycle.
- R7: The first precharge cycle begins on the second rising clock edge after `wake_req` changes. One edge captures the input and one edge moves the state machine.
- R8: A change of `wake_req` during a sequence does not alter that sequence. If, at its end, the level asks for the other operation, that operation's first cycle follows the done cycle after exactly one idle cycle.
- R9: A level that matches the current state causes no sequence. This includes a level that changes and then returns before the running sequence ends.
- R10: A store lasts no more than 7 µs of cycles and a recall no more than 3 µs of cycles at the clock frequency parameter `CLK_MHZ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wake_req | input | 1 | Requested state level: 0 sleep (store), 1 wake (recall) |
| ff_clk_gate | output | 1 | 1 freezes the clock of all volatile and nonvolatile registers |
| cell_rw | output | 1 | Cell access direction: 1 write (store), 0 read (recall) |
| cell_pch | output | 1 | Precharge enable to the cells |
| cell_pl | output | 1 | Plate-line pulse to the cells |
| busy | output | 1 | A store or recall is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
After a change of `wake_req`, the outputs hold their idle values for two cycles. The first precharge cycle is the third cycle seen at the falling edges. Each phase then lasts exactly its parameter length, the done cycle follows the last settle cycle, and at least one idle cycle comes before any deferred sequence. The driver turns each stimulus into one expected output word per cycle from that point on. The monitor compares one word at every falling edge, so a one-cycle shift in any phase shows up as a mismatch. Input changes made in the middle of a sequence go in at fixed offsets after its start. The expected stream stays the same whatever the change.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_PRE    = 3'd1,
    SQ_PLATE  = 3'd2,
    SQ_SETTLE = 3'd3,
    SQ_DONE   = 3'd4
  } sq_state_t;

  localparam int unsigned NPHASE = 3;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nvb_rst_sync.sv
module nvb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/nvb_phase_timer.sv
module nvb_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          ovf
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign ovf = en && (cnt_q == CW'(limit - 1'b1));

  always_comb begin
    if (en && !ovf) cnt_d = cnt_q + 1'b1;
    else            cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R3
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/nvb_seq_fsm.sv
module nvb_seq_fsm
  import nvb_pkg::*;
#(
  parameter int unsigned ST_BUD = 1750,
  parameter int unsigned RC_BUD = 750
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wake_req,
  input  logic [NPHASE-1:0] ovf,
  output logic [NPHASE-1:0] phase_en,
  output logic              op_store,
  output logic              cg,
  output logic              rw,
  output logic              pch,
  output logic              pl,
  output logic              busy,
  output logic              done
);
  localparam int unsigned RLW = $clog2(ST_BUD + RC_BUD + 2);

  sq_state_t st_q, st_d;
  logic req_q, op_q, op_d, awake_q, awake_d;
  logic cg_d, rw_d, pch_d, pl_d, busy_d, done_d;

  assign phase_en = {st_q == SQ_SETTLE, st_q == SQ_PLATE, st_q == SQ_PRE};
  assign op_store = op_q;

  // next-state process
  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    awake_d = awake_q;
    unique case (st_q)
      SQ_IDLE: if (req_q != awake_q) begin
        st_d = SQ_PRE;
        op_d = !req_q;
      end
      SQ_PRE:    if (ovf[0]) st_d = SQ_PLATE;
      SQ_PLATE:  if (ovf[1]) st_d = SQ_SETTLE;
      SQ_SETTLE: if (ovf[2]) begin
        st_d    = SQ_DONE;
        awake_d = !op_q;
      end
      SQ_DONE:   st_d = SQ_IDLE;
      default:   st_d = SQ_IDLE;
    endcase
    busy_d = (st_d == SQ_PRE) || (st_d == SQ_PLATE) || (st_d == SQ_SETTLE);
    pch_d  = (st_d == SQ_PRE);
    pl_d   = (st_d == SQ_PLATE);
    rw_d   = busy_d && op_d;
    done_d = (st_d == SQ_DONE);
    cg_d   = busy_d || !awake_d;
  end

  // register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      req_q   <= 1'b0;
      op_q    <= 1'b0;
      awake_q <= 1'b0;
      cg      <= 1'b1;
      rw      <= 1'b0;
      pch     <= 1'b0;
      pl      <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      st_q    <= st_d;
      req_q   <= wake_req;
      op_q    <= op_d;
      awake_q <= awake_d;
      cg      <= cg_d;
      rw      <= rw_d;
      pch     <= pch_d;
      pl      <= pl_d;
      busy    <= busy_d;
      done    <= done_d;
    end
  end

  // run-length counter for the budget check
  logic [RLW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R4
  pl_pch_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(pl && pch));
  // R5
  gate_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> cg);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);
  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |-> done);
  // R2
  rw_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> !rw);
  // R2
  rw_steady_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(rw));
  // R3
  pch_first_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> pch);
  // R10
  budget_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> (run_q < (op_q ? RLW'(ST_BUD) : RLW'(RC_BUD))));
endmodule

// File: rtl/nvff_backup_ctrl.sv
module nvff_backup_ctrl
  import nvb_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 250,
  parameter int unsigned ST_T1   = 3,
  parameter int unsigned ST_T2   = 6,
  parameter int unsigned ST_T3   = 4,
  parameter int unsigned RC_T1   = 2,
  parameter int unsigned RC_T2   = 3,
  parameter int unsigned RC_T3   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_req,
  output logic ff_clk_gate,
  output logic cell_rw,
  output logic cell_pch,
  output logic cell_pl,
  output logic busy,
  output logic done
);
  localparam int unsigned ST_BUD = 7 * CLK_MHZ;
  localparam int unsigned RC_BUD = 3 * CLK_MHZ;
  localparam int unsigned MAXLEN = max3(max3(ST_T1, ST_T2, ST_T3), max3(RC_T1, RC_T2, RC_T3), 1);
  localparam int unsigned CW     = $clog2(MAXLEN + 1);

  logic              rst_ni;
  logic [NPHASE-1:0] ovf, phase_en;
  logic              op_store;

  nvb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_no(rst_ni));

  for (genvar g = 0; g < NPHASE; g++) begin : g_tmr
    localparam int unsigned ST_LEN = (g == 0) ? ST_T1 : ((g == 1) ? ST_T2 : ST_T3);
    localparam int unsigned RC_LEN = (g == 0) ? RC_T1 : ((g == 1) ? RC_T2 : RC_T3);
    logic [CW-1:0] lim;
    assign lim = op_store ? CW'(ST_LEN) : CW'(RC_LEN);
    nvb_phase_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_ni(rst_ni), .en(phase_en[g]), .limit(lim), .ovf(ovf[g])
    );
  end

  nvb_seq_fsm #(.ST_BUD(ST_BUD), .RC_BUD(RC_BUD)) u_fsm (
    .clk(clk), .rst_ni(rst_ni), .wake_req(wake_req), .ovf(ovf),
    .phase_en(phase_en), .op_store(op_store),
    .cg(ff_clk_gate), .rw(cell_rw), .pch(cell_pch), .pl(cell_pl),
    .busy(busy), .done(done)
  );
endmodule

// File: tb/sim_nvff_backup_ctrl.sv
`timescale 1ns/1ps
module sim_nvff_backup_ctrl;
  localparam int ST1 = 3, ST2 = 6, ST3 = 4;
  localparam int RC1 = 2, RC2 = 3, RC3 = 2;
  localparam int MHZ = 250;

  typedef struct {
    logic [5:0] v;   // {cg, rw, pch, pl, busy, done}
    string      tag;
  } exp_t;

  logic clk, rst_n, wake_req;
  logic ff_clk_gate, cell_rw, cell_pch, cell_pl, busy, done;
  int   total, bad;
  bit   finished;
  exp_t q[$];

  nvff_backup_ctrl #(.CLK_MHZ(MHZ), .ST_T1(ST1), .ST_T2(ST2), .ST_T3(ST3),
                     .RC_T1(RC1), .RC_T2(RC2), .RC_T3(RC3)) u0 (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .ff_clk_gate(ff_clk_gate),
    .cell_rw(cell_rw), .cell_pch(cell_pch), .cell_pl(cell_pl),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [5:0] outs();
    return {ff_clk_gate, cell_rw, cell_pch, cell_pl, busy, done};
  endfunction

  task automatic chk(input logic [5:0] exp, input string tag);
    total++;
    if (outs() !== exp) begin
      bad++;
      $display("FAIL %s: got %b exp %b", tag, outs(), exp);
    end
  endtask

  task automatic push(input logic [5:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_idle(input int n, input bit awake, input string tag);
    for (int i = 0; i < n; i++) push({!awake, 5'b00000}, tag);
  endtask

  task automatic push_seq(input bit st);
    int l1, l2, l3;
    l1 = st ? ST1 : RC1; l2 = st ? ST2 : RC2; l3 = st ? ST3 : RC3;
    for (int i = 0; i < l1; i++) push({1'b1, st, 4'b1010}, "R2/R3/R5 precharge");
    for (int i = 0; i < l2; i++) push({1'b1, st, 4'b0110}, "R3/R4/R5 plate");
    for (int i = 0; i < l3; i++) push({1'b1, st, 4'b0010}, "R3/R5 settle");
    // R10: busy length is the phase sum, which is within the budget
    if (l1 + l2 + l3 > (st ? 7 * MHZ : 3 * MHZ)) begin
      bad++;
      $display("FAIL R10: got %0d exp <= budget", l1 + l2 + l3);
    end
    push({st, 5'b00001}, "R5/R6/R10 done");
  endtask

  task automatic drive(input logic v);
    @(posedge clk); #1 wake_req = v;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.v, e.tag);
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got hang exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0; wake_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(6'b100000, "R1 in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    push_idle(12, 1'b0, "R1 asleep after reset");
    drain();

    // recall, then matching level held (R7 latency, R9 no effect)
    drive(1'b1);
    push_idle(2, 1'b0, "R7 latency");
    push_seq(1'b0);
    push_idle(6, 1'b1, "R9 awake hold");
    drain();

    // store
    drive(1'b0);
    push_idle(2, 1'b1, "R7 latency");
    push_seq(1'b1);
    push_idle(4, 1'b0, "R5 gate held after store");
    drain();

    // R8: sleep requested during a recall -> store after one idle cycle
    drive(1'b1);
    push_idle(2, 1'b0, "R7 latency");
    push_seq(1'b0);
    push_idle(1, 1'b1, "R8 gap");
    push_seq(1'b1);
    push_idle(4, 1'b0, "R8 after");
    repeat (4) @(posedge clk);
    #1 wake_req = 1'b0;
    drain();

    // R9: toggle and return during a recall -> nothing more
    drive(1'b1);
    push_idle(2, 1'b0, "R7 latency");
    push_seq(1'b0);
    push_idle(6, 1'b1, "R9 returned level");
    repeat (3) @(posedge clk);
    #1 wake_req = 1'b0;
    repeat (2) @(posedge clk);
    #1 wake_req = 1'b1;
    drain();

    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule